// File: doc/BRIEF.md
# AC-link codec command decoder

This block sits on the codec side of an AC-link serial interface and picks register commands out of the controller's output stream. A rising edge on the sync input marks the first bit of slot 0. From there the block counts bit times and keeps only the fields a command needs: the frame valid flag, the two command tag bits, the 2-bit codec ID field at the bottom of slot 0, the read/write flag and register index in slot 1, and the data word in slot 2.

Two strap inputs give the device its physical ID, and that ID decides how a command is accepted. With ID 00 the device is the primary codec. It only answers frames whose ID field is 00, and it relies on the command tag bits. With a non-zero ID the device is a secondary codec. The ID field then works as a chip select: a frame whose ID field equals the strap value is taken, and the tag bits are ignored. An accepted command produces a one-cycle read or write strobe together with the register index and the data. Register storage and the read return path are left to the surrounding logic.

Top module: `ac_cmd_decoder`

## Requirements
- R1: After reset both strobes are low and the register index and data outputs are zero.
- R2: A rising edge of the sync input (sync high in a cycle, low in the cycle before) marks bit 15 of slot 0, the first bit of a frame. Bits arrive MSB first: 16 bits of slot 0, then 20 bits of slot 1, then 20 bits of slot 2. A new rising edge in the middle of a frame restarts bit counting, and the partial frame issues no command.
- R3: An accepted command raises exactly one strobe for exactly one cycle. That cycle is the one after the clock edge that samples the 56th bit of the frame, counting the bit sampled on the sync edge as the first.
- R4: A frame whose slot 0 bit 15 (frame valid) is 0 produces no strobe.
- R5: With strap ID 00, a frame whose slot 0 bits 1:0 are 00 is accepted. If slot 1 bit 19 is 1, it is a read when slot 0 bit 14 is 1. If slot 1 bit 19 is 0, it is a write when slot 0 bits 14 and 13 are both 1.
- R6: With a non-zero strap ID, a frame whose slot 0 bits 1:0 equal the strap ID is accepted whatever slot 0 bits 14 and 13 hold. Slot 1 bit 19 = 1 gives a read strobe and 0 gives a write strobe.
- R7: A frame whose slot 0 bits 1:0 differ from the strap ID produces no strobe. This covers a primary device seeing a non-zero field and a secondary device seeing 00 or another ID.
- R8: With each strobe, the register index output carries slot 1 bits 18:12 and the data output carries slot 2 bits 19:4. Both outputs keep their values until the next strobe.
- R9: On a primary device, a write frame with bit 14 set and bit 13 clear gives no strobe, and a read frame with bit 14 clear gives no strobe.
- R10: After the 56th bit, no further strobe is issued until a new sync rising edge starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; each rising edge samples one serial bit |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync; its rising edge marks the first bit of slot 0 |
| sdata_i | input | 1 | Serial data from the controller, MSB first |
| strap_id_i | input | 2 | Physical codec ID from strap pins; 00 selects primary behaviour |
| rd_stb_o | output | 1 | One-cycle register read command |
| wr_stb_o | output | 1 | One-cycle register write command |
| reg_addr_o | output | 7 | Register index from slot 1 bits 18:12 |
| wr_data_o | output | 16 | Data from slot 2 bits 19:4 |

## Verification
The bench drives every serial bit on a falling clock edge, so the rising edge that follows samples it. The command is due one cycle after the edge that samples the 56th bit. The bench therefore reads the strobes, index and data at the first falling edge after that bit. At the next falling edge it confirms that the strobe has dropped and that a strobe counter, updated at rising edges, has moved by exactly the expected amount. For rejected frames, partial frames and idle stretches, the same counter and the held index and data outputs show that nothing was issued.

// File: rtl/ac_cmd_pkg.sv
package ac_cmd_pkg;

    // Default frame geometry and field sizes
    localparam int unsigned ACL_SLOT0_BITS = 16;
    localparam int unsigned ACL_SLOT_BITS  = 20;
    localparam int unsigned ACL_ID_BITS    = 2;
    localparam int unsigned ACL_ADDR_BITS  = 7;
    localparam int unsigned ACL_DATA_BITS  = 16;

    // Number of flag bits captured from the top of slot 0: frame valid, address tag, data tag
    localparam int unsigned ACL_FLAG_BITS  = 3;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic frame_ok;
        logic tag_addr;
        logic tag_data;
    } slot0_flags_t;

    // Acceptance rule: a primary device trusts the tags, a secondary one the ID field
    function automatic cmd_kind_e classify(
        input slot0_flags_t flags,
        input logic         id_match,
        input logic         primary,
        input logic         rd_req
    );
        if (!flags.frame_ok || !id_match) begin
            return CMD_NONE;
        end
        if (primary) begin
            if (rd_req) begin
                return flags.tag_addr ? CMD_READ : CMD_NONE;
            end
            return (flags.tag_addr && flags.tag_data) ? CMD_WRITE : CMD_NONE;
        end
        return rd_req ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/ac_frame_timer.sv
module ac_frame_timer #(
    parameter int unsigned FRAME_BITS = 56,
    parameter int unsigned CNT_W      = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sync_i,
    output logic             bit_vld_o,
    output logic [CNT_W-1:0] bit_idx_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    logic             sync_q;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    // A rising sync edge always starts a fresh frame, even in the middle of one
    assign rise      = sync_i && !sync_q;
    assign bit_vld_o = rise || active_q;
    assign bit_idx_o = rise ? '0 : cnt_q;
    assign last_o    = bit_vld_o && (bit_idx_o == LAST_IDX);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q   <= 1'b0;
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            sync_q <= sync_i;
            if (bit_vld_o) begin
                active_q <= !last_o;
                cnt_q    <= bit_idx_o + 1'b1;
            end
        end
    end

    p_idx_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_o |-> (bit_idx_o < CNT_W'(FRAME_BITS)));

    p_idx_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_o && !last_o) |=>
            (bit_vld_o && ((bit_idx_o == $past(bit_idx_o) + 1'b1) || (bit_idx_o == '0))));

    p_idle_after_last_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        last_o |=> (!bit_vld_o || (bit_idx_o == '0)));

endmodule

// File: rtl/ac_field_capture.sv
module ac_field_capture #(
    parameter int unsigned SLOT0_BITS = 16,
    parameter int unsigned SLOT_BITS  = 20,
    parameter int unsigned ID_BITS    = 2,
    parameter int unsigned ADDR_BITS  = 7,
    parameter int unsigned DATA_BITS  = 16,
    parameter int unsigned CNT_W      = 6
) (
    input  logic                                                   clk_i,
    input  logic                                                   rst_i,
    input  logic                                                   bit_vld_i,
    input  logic [CNT_W-1:0]                                       bit_idx_i,
    input  logic                                                   sd_i,
    output logic [ac_cmd_pkg::ACL_FLAG_BITS+ID_BITS+ADDR_BITS+DATA_BITS:0] fields_o
);

    localparam int NF = 4;
    localparam int FLG = ac_cmd_pkg::ACL_FLAG_BITS;
    // Field widths: flags, ID field, read flag plus index, data
    localparam int FW [NF] = '{FLG, ID_BITS, ADDR_BITS + 1, DATA_BITS};
    // First frame bit index of each field
    localparam int FS [NF] = '{0, SLOT0_BITS - ID_BITS, SLOT0_BITS, SLOT0_BITS + SLOT_BITS};
    // Position of each field inside the packed output
    localparam int FO [NF] = '{0, FLG, FLG + ID_BITS, FLG + ID_BITS + ADDR_BITS + 1};

    // Only the bits a command needs are kept; reserved slot bits pass by
    for (genvar g = 0; g < NF; g++) begin : g_field
        logic [FW[g]-1:0] sh_q;
        logic             hit;

        assign hit = bit_vld_i
                     && (int'(bit_idx_i) >= FS[g])
                     && (int'(bit_idx_i) < FS[g] + FW[g]);

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                sh_q <= '0;
            end else if (hit) begin
                sh_q <= {sh_q[FW[g]-2:0], sd_i};
            end
        end

        assign fields_o[FO[g] +: FW[g]] = sh_q;
    end

    p_fields_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_vld_i |=> $stable(fields_o));

endmodule

// File: rtl/ac_cmd_match.sv
module ac_cmd_match
    import ac_cmd_pkg::*;
#(
    parameter int unsigned ID_BITS   = 2,
    parameter int unsigned ADDR_BITS = 7,
    parameter int unsigned DATA_BITS = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 done_i,
    input  slot0_flags_t         flags_i,
    input  logic [ID_BITS-1:0]   id_rx_i,
    input  logic [ID_BITS-1:0]   strap_i,
    input  logic                 rd_req_i,
    input  logic [ADDR_BITS-1:0] addr_i,
    input  logic [DATA_BITS-1:0] data_i,
    output logic                 rd_stb_o,
    output logic                 wr_stb_o,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic [DATA_BITS-1:0] data_o
);

    cmd_kind_e kind;

    always_comb begin
        kind = classify(flags_i, id_rx_i == strap_i, strap_i == '0, rd_req_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_stb_o <= 1'b0;
            wr_stb_o <= 1'b0;
            addr_o   <= '0;
            data_o   <= '0;
        end else begin
            rd_stb_o <= done_i && (kind == CMD_READ);
            wr_stb_o <= done_i && (kind == CMD_WRITE);
            if (done_i && (kind != CMD_NONE)) begin
                addr_o <= addr_i;
                data_o <= data_i;
            end
        end
    end

    p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stb_o || wr_stb_o) |=> !(rd_stb_o || wr_stb_o));

    p_excl_strobes_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rd_stb_o && wr_stb_o));

    p_frame_valid_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stb_o || wr_stb_o) |-> $past(flags_i.frame_ok));

    p_chip_select_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stb_o || wr_stb_o) |-> $past(id_rx_i == strap_i));

    p_primary_write_tags_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_stb_o && ($past(strap_i) == '0)) |-> $past(flags_i.tag_addr && flags_i.tag_data));

    p_outputs_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rd_stb_o || wr_stb_o) |-> ($stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/ac_cmd_decoder.sv
module ac_cmd_decoder
    import ac_cmd_pkg::*;
#(
    parameter int unsigned SLOT0_BITS = ACL_SLOT0_BITS,
    parameter int unsigned SLOT_BITS  = ACL_SLOT_BITS,
    parameter int unsigned ID_BITS    = ACL_ID_BITS,
    parameter int unsigned ADDR_BITS  = ACL_ADDR_BITS,
    parameter int unsigned DATA_BITS  = ACL_DATA_BITS
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 sync_i,
    input  logic                 sdata_i,
    input  logic [ID_BITS-1:0]   strap_id_i,
    output logic                 rd_stb_o,
    output logic                 wr_stb_o,
    output logic [ADDR_BITS-1:0] reg_addr_o,
    output logic [DATA_BITS-1:0] wr_data_o
);

    localparam int unsigned FRAME_BITS = SLOT0_BITS + 2 * SLOT_BITS;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int unsigned FLG        = ACL_FLAG_BITS;
    localparam int unsigned FIELD_W    = FLG + ID_BITS + ADDR_BITS + 1 + DATA_BITS;
    localparam int unsigned ID_LO      = FLG;
    localparam int unsigned CMD_LO     = FLG + ID_BITS;
    localparam int unsigned DATA_LO    = FLG + ID_BITS + ADDR_BITS + 1;

    logic               bit_vld;
    logic [CNT_W-1:0]   bit_idx;
    logic               frame_last;
    logic [FIELD_W-1:0] fields;
    slot0_flags_t       flags;

    ac_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sync_i    (sync_i),
        .bit_vld_o (bit_vld),
        .bit_idx_o (bit_idx),
        .last_o    (frame_last)
    );

    ac_field_capture #(
        .SLOT0_BITS (SLOT0_BITS),
        .SLOT_BITS  (SLOT_BITS),
        .ID_BITS    (ID_BITS),
        .ADDR_BITS  (ADDR_BITS),
        .DATA_BITS  (DATA_BITS),
        .CNT_W      (CNT_W)
    ) u_capture (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bit_vld_i (bit_vld),
        .bit_idx_i (bit_idx),
        .sd_i      (sdata_i),
        .fields_o  (fields)
    );

    // First received bit lands at the top of the flag field
    assign flags = slot0_flags_t'(fields[FLG-1:0]);

    ac_cmd_match #(
        .ID_BITS   (ID_BITS),
        .ADDR_BITS (ADDR_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_match (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .done_i   (frame_last),
        .flags_i  (flags),
        .id_rx_i  (fields[ID_LO +: ID_BITS]),
        .strap_i  (strap_id_i),
        .rd_req_i (fields[CMD_LO + ADDR_BITS]),
        .addr_i   (fields[CMD_LO +: ADDR_BITS]),
        .data_i   (fields[DATA_LO +: DATA_BITS]),
        .rd_stb_o (rd_stb_o),
        .wr_stb_o (wr_stb_o),
        .addr_o   (reg_addr_o),
        .data_o   (wr_data_o)
    );

    p_strobe_after_last_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_stb_o || wr_stb_o) |-> $past(frame_last));

endmodule

// File: tb/tb_ac_cmd_decoder.sv
module tb_ac_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 150;

    logic        clk = 1'b0;
    logic        rst;
    logic        sync;
    logic        sdata;
    logic [1:0]  strap;
    logic        rd_stb;
    logic        wr_stb;
    logic [6:0]  reg_addr;
    logic [15:0] wr_data;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          pulses  = 0;
    bit          finished = 1'b0;
    logic [6:0]  exp_addr = '0;
    logic [15:0] exp_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ac_cmd_decoder dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .sync_i     (sync),
        .sdata_i    (sdata),
        .strap_id_i (strap),
        .rd_stb_o   (rd_stb),
        .wr_stb_o   (wr_stb),
        .reg_addr_o (reg_addr),
        .wr_data_o  (wr_data)
    );

    // Strobe counter sampled at rising edges (value held during the prior cycle)
    always @(posedge clk) begin
        if (!rst && (rd_stb || wr_stb)) pulses++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 = none, 1 = read, 2 = write
    function automatic int exp_kind(input logic [1:0] sid, input logic [15:0] s0,
                                    input logic [19:0] s1);
        if (!s0[15] || (s0[1:0] != sid)) return 0;
        if (sid == 2'b00) begin
            if (s1[19]) return s0[14] ? 1 : 0;
            return (s0[14] && s0[13]) ? 2 : 0;
        end
        return s1[19] ? 1 : 2;
    endfunction

    function automatic logic frame_bit(input int k, input logic [15:0] s0,
                                       input logic [19:0] s1, input logic [19:0] s2);
        if (k < 16) return s0[15 - k];
        if (k < 36) return s1[19 - (k - 16)];
        return s2[19 - (k - 36)];
    endfunction

    task automatic send_bits(input logic [15:0] s0, input logic [19:0] s1,
                             input logic [19:0] s2, input int nbits);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            sync  = (k < 16);
            sdata = frame_bit(k, s0, s1, s2);
        end
    endtask

    task automatic run_frame(input logic [15:0] s0, input logic [19:0] s1,
                             input logic [19:0] s2, input string req);
        int p0;
        int kind;
        p0   = pulses;
        kind = exp_kind(strap, s0, s1);
        send_bits(s0, s1, s2, 56);
        @(negedge clk);
        sync  = 1'b0;
        sdata = 1'($urandom);
        if (kind != 0) begin
            exp_addr = s1[18:12];
            exp_data = s2[19:4];
        end
        chk(rd_stb == (kind == 1), req, "rd_stb", rd_stb, kind == 1);
        chk(wr_stb == (kind == 2), req, "wr_stb", wr_stb, kind == 2);
        chk(reg_addr == exp_addr, "R8", "reg_addr", reg_addr, exp_addr);
        chk(wr_data == exp_data, "R8", "wr_data", wr_data, exp_data);
        @(negedge clk);
        chk(!rd_stb && !wr_stb, "R3", "strobe drop", {rd_stb, wr_stb}, 0);
        chk((pulses - p0) == ((kind != 0) ? 1 : 0), "R3", "pulse count",
            pulses - p0, (kind != 0) ? 1 : 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] s0;
        logic [19:0] s1;
        logic [19:0] s2;
        int          p0;
        void'($urandom(32'h5eed_a11c));
        rst   = 1'b1;
        sync  = 1'b0;
        sdata = 1'b0;
        strap = 2'b00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!rd_stb && !wr_stb, "R1", "strobes", {rd_stb, wr_stb}, 0);
        chk(reg_addr == '0, "R1", "reg_addr", reg_addr, 0);
        chk(wr_data == '0, "R1", "wr_data", wr_data, 0);

        // R5: primary read and write
        run_frame(16'hE000, {1'b1, 7'h26, 12'h000}, 20'hABCD0, "R5");
        run_frame(16'hE000, {1'b0, 7'h02, 12'h000}, 20'h80800, "R5");
        // R9: primary write lacking data tag, read lacking address tag
        run_frame(16'hC000, {1'b0, 7'h11, 12'h000}, 20'h12340, "R9");
        run_frame(16'hA000, {1'b1, 7'h12, 12'h000}, 20'h55550, "R9");
        // R7: primary sees a non-zero ID field
        run_frame(16'hE002, {1'b1, 7'h13, 12'h000}, 20'h0F0F0, "R7");
        // R4: frame valid clear
        run_frame(16'h6000, {1'b1, 7'h14, 12'h000}, 20'h11110, "R4");

        // R6: secondaries with tags clear
        strap = 2'b10;
        run_frame(16'h8002, {1'b1, 7'h7C, 12'hFFF}, 20'hFEDCF, "R6");
        run_frame(16'h8002, {1'b0, 7'h5A, 12'h000}, 20'hC0DE0, "R6");
        strap = 2'b01;
        run_frame(16'h8001, {1'b0, 7'h01, 12'h000}, 20'h00010, "R6");
        strap = 2'b11;
        run_frame(16'hE003, {1'b1, 7'h7F, 12'h000}, 20'hFFFF0, "R6");
        // R7: secondary sees 00 and another ID
        run_frame(16'hE000, {1'b1, 7'h33, 12'h000}, 20'h33330, "R7");
        run_frame(16'h8001, {1'b0, 7'h34, 12'h000}, 20'h44440, "R7");
        // R4: secondary, matching ID but frame invalid
        run_frame(16'h0003, {1'b0, 7'h35, 12'h000}, 20'h45450, "R4");

        // R2: frame cut short by a new sync edge, then a full frame
        p0 = pulses;
        send_bits(16'h8003, {1'b0, 7'h40, 12'h000}, 20'h99990, 30);
        @(negedge clk);
        sync = 1'b0;
        chk(pulses == p0, "R2", "partial frame pulses", pulses - p0, 0);
        run_frame(16'h8003, {1'b0, 7'h41, 12'h000}, 20'h24680, "R2");

        // R10: long idle stretch with noise on the data line
        p0 = pulses;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            sync  = 1'b0;
            sdata = 1'($urandom);
        end
        @(negedge clk);
        chk(pulses == p0, "R10", "idle pulses", pulses - p0, 0);
        chk(reg_addr == exp_addr, "R10", "idle reg_addr", reg_addr, exp_addr);

        // Random frames, half with a matching ID field (R5 R6 R7 R4 R8)
        for (int n = 0; n < NRAND; n++) begin
            if ((n % 10) == 0) strap = 2'($urandom);
            s0 = 16'($urandom);
            s1 = 20'($urandom);
            s2 = 20'($urandom);
            if ($urandom_range(0, 1) == 1) s0[1:0] = strap;
            if ($urandom_range(0, 3) != 0) s0[15] = 1'b1;
            run_frame(s0, s1, s2, "R6_rand");
        end

        finish_run();
    end

endmodule